// File: doc/BRIEF.md
# Note-Code Tone Generator

This block turns a 5-bit musical note code into a square wave that can drive a speaker. The upper bit of the code picks the octave and the lower four bits pick a note inside it. A table maps each code to a 16-bit half-period count. On every clock edge that value is captured into a register.

A counter advances only on a 1 MHz enable strobe, which is made elsewhere from the system clock. The speaker bit flips each time the counter completes one half-period. The tone frequency is therefore 1 MHz divided by twice the count. For example, a count of 1136 gives roughly 440 Hz. A zero count mutes the speaker.

The note code is a level-held control input and the speaker bit is a plain output. Neither is a data stream, so there is no valid/ready handshake at the edge of the block.

Top module: `tone_gen`

## Requirements
- R1: With bit 4 of the code set, the low index maps as follows: 0→2025, 1→1911, 2→1804, 3→1703, 4→1607, 5→1517, 6→1432, 7→1351, 8→1275, 9→1204, 10→1136, 11→1073 and 12→1012. With bit 4 clear, index 12 maps to 2025 and index 13 maps to 1911.
- R2: Every code not listed in R1 gives a half-period of zero.
- R3: `half_period` shows the table value for the code present at one rising clock edge, starting right after that edge. Before that edge it still holds the previous value.
- R4: The counter and speaker bit change only on clock edges where `tick_1m` is high. A run of clock edges without the strobe leaves the speaker bit unchanged.
- R5: For a steady nonzero half-period D, the speaker bit flips on every D-th strobe. The full period is 2·D strobes, and the bit is high during the second D strobes after a restart.
- R6: While `half_period` is zero, `spk_out` is low in the same cycle, and strobes have no effect.
- R7: When the half-period changes, the next clock edge clears the count and drives the speaker bit low. Any strobe on or before that edge is discarded. The first rise then comes on the D-th strobe that follows.
- R8: While `rst_n` is low, the registered half-period, the count and the speaker bit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1m | input | 1 | One-cycle 1 MHz count enable |
| note_code | input | 5 | Octave bit (4) and note index (3:0) |
| spk_out | output | 1 | Square-wave speaker drive |
| half_period | output | 16 | Registered half-period count in strobes |

## Verification
A new code shows up on `half_period` after exactly one rising edge. The bench samples it half a cycle before that edge, where it must still be old, and half a cycle after, where it must be new. The count restart lands on the second edge after a code change, so the bench holds the strobe low for two edges before it counts. It then checks `spk_out` half a cycle after the (D−1)-th, D-th, (2D−1)-th and 2D-th strobe. All inputs are driven and all outputs are sampled on the falling edge, and random idle gaps between strobes test that only strobed edges count.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int CODE_W = 5;
  localparam int DIV_W  = 16;

  function automatic logic [DIV_W-1:0] code_to_div(input logic [CODE_W-1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      5'b01100: d = 16'd2025;
      5'b01101: d = 16'd1911;
      5'b10000: d = 16'd2025;
      5'b10001: d = 16'd1911;
      5'b10010: d = 16'd1804;
      5'b10011: d = 16'd1703;
      5'b10100: d = 16'd1607;
      5'b10101: d = 16'd1517;
      5'b10110: d = 16'd1432;
      5'b10111: d = 16'd1351;
      5'b11000: d = 16'd1275;
      5'b11001: d = 16'd1204;
      5'b11010: d = 16'd1136;
      5'b11011: d = 16'd1073;
      5'b11100: d = 16'd1012;
      default:  d = '0;   // R2: unlisted codes mute
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tone_lut.sv
module tone_lut
  import tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output logic [DIV_W-1:0]  div_o
);
  // R1/R3: table value captured on the clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_o <= '0;
    else        div_o <= code_to_div(code_i);
  end
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tog_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_prev_q;
  logic             tog_q;
  logic             restart;

  assign restart = (div_i != div_prev_q) || (div_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      div_prev_q <= '0;
      tog_q      <= 1'b0;
    end else begin
      div_prev_q <= div_i;
      if (restart) begin
        cnt_q <= '0;
        tog_q <= 1'b0;
      end else if (tick_i) begin
        if (cnt_q == div_i - ONE) begin
          cnt_q <= '0;
          tog_q <= ~tog_q;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
    end
  end

  assign tog_o = tog_q;

  // R4: no strobe and a steady divisor leave the wave alone
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && $stable(div_i)) |=> $stable(tog_q));
  // R5: count never reaches the divisor while it is steady
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i != '0 && $stable(div_i)) |-> (cnt_q < div_i));
  // R7: a divisor change restarts from zero, low
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_i) |=> (cnt_q == '0 && !tog_q));
  // R6: zero divisor keeps the divider idle
  p_mute_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i == '0) |=> (cnt_q == '0 && !tog_q));
endmodule

// File: rtl/tone_gen.sv
module tone_gen
  import tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1m,
  input  logic [CODE_W-1:0] note_code,
  output logic              spk_out,
  output logic [DIV_W-1:0]  half_period
);
  logic [DIV_W-1:0] div_q;
  logic             tog;

  tone_lut u_lut (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (note_code),
    .div_o  (div_q)
  );

  tone_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_1m),
    .div_i  (div_q),
    .tog_o  (tog)
  );

  // R6: mute in the same cycle the divisor drops to zero
  assign spk_out     = (div_q != '0) & tog;
  assign half_period = div_q;

  // R5: with a settled divisor, the wave moves only after a strobe
  p_spk_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_period != '0 && $past(half_period) == half_period &&
     $past(half_period, 2) == half_period && !$stable(spk_out)) |-> $past(tick_1m));
endmodule

// File: tb/tb_tone_gen.sv
`timescale 1ns/1ps
module tb_tone_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1m = 1'b0;
  logic [4:0]  note_code = '0;
  logic        spk_out;
  logic [15:0] half_period;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tone_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m),
    .note_code(note_code), .spk_out(spk_out), .half_period(half_period)
  );

  function automatic int exp_div(input logic [4:0] c);
    if (c[4]) begin
      case (c[3:0])
        4'd0: return 2025;  4'd1: return 1911;  4'd2: return 1804;
        4'd3: return 1703;  4'd4: return 1607;  4'd5: return 1517;
        4'd6: return 1432;  4'd7: return 1351;  4'd8: return 1275;
        4'd9: return 1204;  4'd10: return 1136; 4'd11: return 1073;
        4'd12: return 1012;
        default: return 0;
      endcase
    end else begin
      if (c[3:0] == 4'd12) return 2025;
      if (c[3:0] == 4'd13) return 1911;
      return 0;
    end
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge with strobe value t; returns at the next falling edge
  task automatic cyc(input bit t);
    tick_1m = t;
    @(negedge clk);
    tick_1m = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap_max);
    for (int i = 0; i < n; i++) begin
      if (gap_max > 0) begin
        int g = $urandom % (gap_max + 1);
        for (int k = 0; k < g; k++) cyc(1'b0);
      end
      cyc(1'b1);
    end
  endtask

  task automatic set_code(input logic [4:0] c);
    note_code = c;
    cyc(1'b0);
    cyc(1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    note_code = 5'b11010;
    repeat (3) @(negedge clk);
    check("R8 reset half_period", half_period, 0);
    check("R8 reset spk", spk_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2/R3: each code, old value before edge, new after
    for (int c = 0; c < 32; c++) begin
      int prev = half_period;
      note_code = c[4:0];
      @(posedge clk); #1;
      @(negedge clk);
      check("R1/R2 table value", half_period, exp_div(c[4:0]));
      note_code = c[4:0] ^ 5'b10000;
      #1.0;
      check("R3 still old before edge", half_period, exp_div(c[4:0]));
      @(negedge clk);
      check("R3 new after edge", half_period, exp_div(c[4:0] ^ 5'b10000));
      if (prev < 0) check("R3 unreachable", 0, 1);
    end

    // R6: unlisted code, strobes do nothing
    set_code(5'b11111);
    check("R2 unlisted zero", half_period, 0);
    ticks(50, 0);
    check("R6 muted with strobes", spk_out, 0);

    // R4/R5: A4 full period, idle stretch in the middle
    set_code(5'b11010);
    check("R7 starts low", spk_out, 0);
    ticks(1135, 0);
    check("R5 before D-th strobe", spk_out, 0);
    for (int k = 0; k < 200; k++) cyc(1'b0);
    check("R4 no strobe no change", spk_out, 0);
    ticks(1, 0);
    check("R5 rise on D-th strobe", spk_out, 1);
    ticks(1135, 0);
    check("R5 high until 2D-1", spk_out, 1);
    ticks(1, 0);
    check("R5 fall on 2D-th strobe", spk_out, 0);

    // R6: divisor to zero while high mutes same cycle
    ticks(1136, 0);
    check("R5 high again", spk_out, 1);
    note_code = 5'b00000;
    cyc(1'b1);
    check("R6 same-cycle mute", spk_out, 0);
    check("R6 half_period zero", half_period, 0);

    // R7: change mid-count, strobes during settle discarded
    set_code(5'b11010);
    ticks(500, 0);
    note_code = 5'b11100;
    cyc(1'b1);
    cyc(1'b1);
    check("R7 low after change", spk_out, 0);
    ticks(1011, 0);
    check("R7 no early rise", spk_out, 0);
    ticks(1, 0);
    check("R7 rise D strobes after restart", spk_out, 1);
    note_code = 5'b10001;
    cyc(1'b0);
    cyc(1'b0);
    check("R7 high cleared by change", spk_out, 0);

    // random codes with random strobe gaps
    for (int t = 0; t < 8; t++) begin
      logic [4:0] c;
      int d;
      if (($urandom % 4) == 0) c = 5'($urandom);
      else c = 5'b10000 | 5'($urandom % 13);
      set_code(c);
      d = exp_div(c);
      check("R1 random table value", half_period, d);
      if (d != 0) begin
        ticks(d - 1, 1);
        check("R5 random before rise", spk_out, 0);
        ticks(1, 1);
        check("R5 random rise", spk_out, 1);
      end else begin
        ticks(20, 1);
        check("R6 random muted", spk_out, 0);
      end
    end

    // R8: reset mid-tone
    set_code(5'b11010);
    ticks(1136, 0);
    rst_n = 1'b0;
    #1;
    check("R8 async reset spk", spk_out, 0);
    check("R8 async reset half_period", half_period, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (R1..) actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule